// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter Stage

This block is a small synchronous counter stage. All state bits change together on the rising clock edge. A parameter picks the counting range: modulo 16 (binary) or modulo 10 (decade). A second parameter picks how the active-low clear behaves. It can act at once, without waiting for a clock edge, or it can act on the next rising edge. When it acts on the edge, an external decode of the outputs can drive the clear to shorten the count length.

Counting needs both enables, `en_p` and `en_t`, to be high. An active-low load copies the parallel data into the counter on the next edge. The load wins over both enables, and the clear wins over everything. Only `en_t` feeds the terminal-carry output. To build a wider synchronous counter, connect each stage's `carry_out` to the next stage's `en_t` and share `en_p` and the clock between all stages. No extra gating is needed.

Top module: `ctr_stage`

## Requirements
- R1: With `clr_n` and `load_n` high and both `en_p` and `en_t` high, every rising edge advances `q` by one.
- R2: With `clr_n` high and `load_n` low, the next rising edge sets `q` to `din`, whatever the enable levels.
- R3: With ASYNC_CLEAR=1, a low `clr_n` forces `q` to 0 at once, without a clock edge, overriding load and enables.
- R4: With ASYNC_CLEAR=0, a low `clr_n` sets `q` to 0 on the next rising edge, overriding load and enables. Before that edge, `q` keeps its value.
- R5: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R6: `carry_out` is combinational. It is 1 exactly when `en_t` is 1 and `q` equals the terminal value: 15 in binary mode, 9 in decade mode. `en_p` has no effect on it.
- R7: A counting edge at the terminal value returns `q` to 0. In binary mode that is 15 to 0, and in decade mode it is 9 to 0.
- R8: In decade mode, a loaded value from 10 to 15 advances by one per counting edge until 15 wraps to 0. `carry_out` stays 0 at those values.
- R9: In two chained stages (low `carry_out` driving high `en_t`, `en_p` shared), the pair counts as one synchronous counter. Its modulus is 256 in binary mode and 100 in decade mode.
- R10: Priority at an edge is clear, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel preset data |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Count enable that also gates `carry_out` |
| q | output | WIDTH | Counter state |
| carry_out | output | 1 | Terminal-count carry, gated by `en_t` |

## Verification
The bench builds two chained pairs side by side, and both pairs see the same stimulus. One pair uses DECADE=0 with ASYNC_CLEAR=0. The other uses DECADE=1 with ASYNC_CLEAR=1. This covers both counting ranges, both clear timings, the off-range decade values 10 to 15 and the 99-to-0 and 255-to-0 cascade rollovers in one run. Because the stimulus is shared, one pair shows `q` changing at once on a clear while the other pair shows it waiting for the edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Operation chosen for the coming clock edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
    import ctr_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output ctr_op_e op
);
    // Clear beats load, load beats count, count beats hold.
    always_comb begin
        if (!clr_n)             op = OP_CLEAR;
        else if (!load_n)       op = OP_LOAD;
        else if (en_p && en_t)  op = OP_COUNT;
        else                    op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_incr.sv
module ctr_incr #(
    parameter int WIDTH = 4,
    parameter int TERM  = 15
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] TERM_V = TERM[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ONE_V  = {{(WIDTH-1){1'b0}}, 1'b1};

    // The terminal value wraps to zero. So does the all-ones value, which
    // lets out-of-range decade values run up to it and then wrap.
    always_comb begin
        if (cur == TERM_V || cur == {WIDTH{1'b1}}) nxt = '0;
        else                                       nxt = cur + ONE_V;
    end
endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
    parameter int WIDTH = 4,
    parameter int TERM  = 15
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TERM_V = TERM[WIDTH-1:0];

    assign tc = en_t && (cur == TERM_V);
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
    import ctr_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit DECADE      = 1'b0,
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    localparam int TERM = DECADE ? 9 : (1 << WIDTH) - 1;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ctr_state_t;

    ctr_state_t       st_d, st_q;
    ctr_op_e          op;
    logic [WIDTH-1:0] inc_val;

    ctr_op_sel u_op (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    ctr_incr #(.WIDTH(WIDTH), .TERM(TERM)) u_inc (
        .cur (st_q.cnt),
        .nxt (inc_val)
    );

    ctr_tc #(.WIDTH(WIDTH), .TERM(TERM)) u_tc (
        .cur  (st_q.cnt),
        .en_t (en_t),
        .tc   (carry_out)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = inc_val;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (ASYNC_CLEAR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign q = st_q.cnt;
endmodule

// File: rtl/ctr_stage_chk.sv
module ctr_stage_chk #(
    parameter int WIDTH       = 4,
    parameter bit DECADE      = 1'b0,
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);
    localparam int               TERM   = DECADE ? 9 : (1 << WIDTH) - 1;
    localparam logic [WIDTH-1:0] TERM_V = TERM[WIDTH-1:0];

    // State is known only after a clear has been seen at an edge.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= armed_q | ~clr_n;

    // R2
    a_r2_load_takes_din: assert property (@(posedge clk) disable iff (!clr_n || !armed_q)
        !load_n |=> q == $past(din));

    // R5
    a_r5_hold_when_disabled: assert property (@(posedge clk) disable iff (!clr_n || !armed_q)
        (load_n && !(en_p && en_t)) |=> $stable(q));

    // R7
    a_r7_wrap_at_terminal: assert property (@(posedge clk) disable iff (!clr_n || !armed_q)
        (load_n && en_p && en_t && q == TERM_V) |=> q == '0);

    // R6
    a_r6_carry_needs_ent: assert property (@(posedge clk) disable iff (!armed_q)
        carry_out |-> (en_t && q == TERM_V));

    generate
        if (ASYNC_CLEAR) begin : g_chk_async
            // R3
            a_r3_async_clear_zero: assert property (@(posedge clk) disable iff (!armed_q)
                !clr_n |-> q == '0);
        end else begin : g_chk_sync
            // R4
            a_r4_sync_clear_zero: assert property (@(posedge clk) disable iff (!armed_q)
                !clr_n |=> q == '0);
        end
    endgenerate
endmodule

bind ctr_stage ctr_stage_chk #(
    .WIDTH       (WIDTH),
    .DECADE      (DECADE),
    .ASYNC_CLEAR (ASYNC_CLEAR)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .din       (din),
    .en_p      (en_p),
    .en_t      (en_t),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/ctr_stage_test.sv
module ctr_stage_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] d_lo = '0, d_hi = '0;
    logic [3:0] qa_lo, qa_hi, qb_lo, qb_hi;
    logic       ca_lo, ca_hi, cb_lo, cb_hi;
    logic [3:0] ma_lo, ma_hi, mb_lo, mb_hi;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;   // 10-unit period, 100 MHz

    // Chain A: binary, synchronous clear
    ctr_stage #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_lo),
        .en_p(en_p), .en_t(en_t), .q(qa_lo), .carry_out(ca_lo));
    ctr_stage #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) uut_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_hi),
        .en_p(en_p), .en_t(ca_lo), .q(qa_hi), .carry_out(ca_hi));
    // Chain B: decade, asynchronous clear
    ctr_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) dec_lo (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_lo),
        .en_p(en_p), .en_t(en_t), .q(qb_lo), .carry_out(cb_lo));
    ctr_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) dec_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_hi),
        .en_p(en_p), .en_t(cb_lo), .q(qb_hi), .carry_out(cb_hi));

    function automatic logic [3:0] ref_next(logic [3:0] cur, logic c, logic l,
                                            logic [3:0] d, logic p, logic t, int term);
        if (!c)              return 4'd0;
        else if (!l)         return d;
        else if (p && t)     return (cur == term[3:0] || cur == 4'hF) ? 4'd0 : cur + 4'd1;
        else                 return cur;
    endfunction

    function automatic logic ref_tc(logic [3:0] cur, logic t, int term);
        return t && (cur == term[3:0]);
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(logic c, logic l, logic [3:0] dl, logic [3:0] dh,
                         logic p, logic t, string tag);
        string tga, tgb, tgc;
        logic [3:0] na_lo, na_hi, nb_lo, nb_hi;
        logic ta, tb;
        clr_n = c; load_n = l; d_lo = dl; d_hi = dh; en_p = p; en_t = t;
        #1;
        tga = (tag != "") ? tag : (!c ? "R4" : !l ? "R2" : (p && t) ? "R1" : "R5");
        tgb = (tag != "") ? tag : (!c ? "R3" : !l ? "R2" : (p && t) ? "R1" : "R5");
        tgc = (tag != "") ? tag : "R6";
        if (!c) begin
            mb_lo = 4'd0; mb_hi = 4'd0;
            check("R3", "async clear now", {qb_hi, qb_lo}, 8'h00);
            check("R4", "sync clear waits", {qa_hi, qa_lo}, {ma_hi, ma_lo});
        end
        ta = ref_tc(ma_lo, t, 15);
        tb = ref_tc(mb_lo, t, 9);
        check(tgc, "carry A lo", {7'd0, ca_lo}, {7'd0, ta});
        check(tgc, "carry A hi", {7'd0, ca_hi}, {7'd0, ref_tc(ma_hi, ta, 15)});
        check(tgc, "carry B lo", {7'd0, cb_lo}, {7'd0, tb});
        check(tgc, "carry B hi", {7'd0, cb_hi}, {7'd0, ref_tc(mb_hi, tb, 9)});
        na_lo = ref_next(ma_lo, c, l, dl, p, t, 15);
        na_hi = ref_next(ma_hi, c, l, dh, p, ta, 15);
        nb_lo = ref_next(mb_lo, c, l, dl, p, t, 9);
        nb_hi = ref_next(mb_hi, c, l, dh, p, tb, 9);
        @(posedge clk);
        @(negedge clk);
        ma_lo = na_lo; ma_hi = na_hi; mb_lo = nb_lo; mb_hi = nb_hi;
        check(tga, "binary pair", {qa_hi, qa_lo}, {ma_hi, ma_lo});
        check(tgb, "decade pair", {qb_hi, qb_lo}, {mb_hi, mb_lo});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd4711);
        // reset via clear
        repeat (2) @(posedge clk);
        @(negedge clk);
        ma_lo = 0; ma_hi = 0; mb_lo = 0; mb_hi = 0;
        check("R4", "reset binary", {qa_hi, qa_lo}, 8'h00);
        check("R3", "reset decade", {qb_hi, qb_lo}, 8'h00);
        // plain counting, then long run across both cascade rollovers
        for (int i = 0; i < 120; i++) cycle(1, 1, 0, 0, 1, 1, "");
        for (int i = 0; i < 150; i++) cycle(1, 1, 0, 0, 1, 1, "R9");
        // terminal wrap
        cycle(1, 0, 4'd9, 4'd0, 0, 0, "R2");
        cycle(1, 1, 0, 0, 1, 1, "R7");
        cycle(1, 0, 4'd15, 4'd2, 1, 0, "R2");
        cycle(1, 1, 0, 0, 1, 1, "R7");
        // decade off-range values
        cycle(1, 0, 4'd12, 4'd3, 0, 1, "R2");
        for (int i = 0; i < 5; i++) cycle(1, 1, 0, 0, 1, 1, "R8");
        // priority
        cycle(0, 0, 4'd5, 4'd5, 1, 1, "R10");
        cycle(1, 0, 4'd5, 4'd1, 1, 1, "R10");
        // hold and carry gating
        cycle(1, 0, 4'd9, 4'd0, 1, 1, "R2");
        cycle(1, 1, 0, 0, 0, 1, "R6");
        cycle(1, 1, 0, 0, 1, 0, "R6");
        cycle(1, 1, 0, 0, 0, 0, "R5");
        cycle(1, 0, 4'd15, 4'd15, 1, 1, "R2");
        cycle(1, 1, 0, 0, 0, 1, "R6");
        cycle(1, 1, 0, 0, 1, 1, "R9");
        // synchronous clear shortening the count: clear after reaching 3
        for (int i = 0; i < 3; i++) cycle(1, 1, 0, 0, 1, 1, "R1");
        cycle(0, 1, 0, 0, 1, 1, "");
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 16) != 0, ($urandom % 8) != 0,
                  4'($urandom), 4'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0, "");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule